// File: doc/BRIEF.md
# Configurable Programmable Logic Array

This block is a sum-of-products array whose AND plane and OR plane are both set at run time. Each product term may use the true or the complemented form of any data input. Each output ORs together any chosen subset of the product terms, and one product term may feed several outputs at once. Every output then passes through an XOR with its own invert bit, so the block can produce either a function or its complement. After the array is configured, the outputs follow the data inputs through purely combinational logic.

Configuration bits arrive one per clock on a serial input while a load strobe is held high. A small controller has three states. `ST_EMPTY` is the state after reset, before any configuration has been loaded. `ST_LOAD` is the state while bits are shifting in. `ST_ACTIVE` is the state once a configuration is complete. The controller moves between them on these transitions:
- EMPTY→LOAD when the strobe rises.
- LOAD→LOAD while the strobe stays high.
- LOAD→ACTIVE on the first clock with the strobe low.
- ACTIVE→LOAD when the strobe is raised again.
- EMPTY→EMPTY and ACTIVE→ACTIVE while the strobe is low.

The outputs are held at zero in every state except `ST_ACTIVE`. This keeps a half-loaded map from ever reaching the outputs. With the default sizes (4 inputs, 8 terms, 4 outputs), the configuration is 100 bits long.

Top module: `pla_array`

## Requirements
- R1: After reset, the controller is in ST_EMPTY, the whole configuration is cleared, and data_out is 0 for every data_in until a load completes.
- R2: While cfg_load is high, cfg_bit is shifted into the configuration one bit per rising clock edge, and data_out is held at 0 on the clock after any cycle with cfg_load high.
- R3: While cfg_load is still high, and right after it falls, data_out stays 0. data_out becomes valid after the first rising edge that samples cfg_load low.
- R4: Each product term has two enable bits per input. Bit 2*i enables the true literal of data_in[i]. Bit 2*i+1 enables the complemented literal. A term is the AND of its enabled literals.
- R5: A product term with no literal enabled evaluates to 1.
- R6: A product term that enables both literals of the same input evaluates to 0.
- R7: Output o is the OR of every term whose connection bit is set for o. A term may be connected to several outputs at once.
- R8: An output with no connected terms gives 0 before its invert stage, so it shows exactly its invert bit.
- R9: Each output is XORed with its invert bit. A set bit complements the output.
- R10: Configuration layout, in vector index order:
  - Invert bit of output o at index o.
  - OR connection of term t to output o at index N_OUT + o*N_TERM + t.
  - AND enable bit b of term t at index N_OUT + N_OUT*N_TERM + t*2*N_IN + b.
  - The bit shifted in first ends at the highest index, so a loader sends the highest index first.
- R11: While cfg_load is low, cfg_bit has no effect on the stored configuration or on data_out.
- R12: With a 3-input map of F1 = A·B' + A·C + A'·B·C' on data_out[0] and F2 = (A·C + B·C)' on data_out[1] (A=data_in[0], B=data_in[1], C=data_in[2]), the array gives both functions for every input combination, with A·C shared between the two outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for configuration loading |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_load | input | 1 | Load strobe; high shifts cfg_bit in each clock |
| cfg_bit | input | 1 | Serial configuration data |
| data_in | input | N_IN | Data inputs to the AND plane |
| data_out | output | N_OUT | Combinational array outputs, zero unless configured |

## Verification
The bench goes after these corner cases:
- Empty and contradictory product terms. If the reduction polarity is wrong, an empty term reads 0 instead of 1, or a term with A·A' leaks through as 1.
- Outputs with no terms connected. A wrong OR default shows up here as an output that ignores its invert bit.
- A term shared by two outputs, including one output that is inverted. A design that duplicates terms per output or gets the invert wrong fails the two-function table.
- The shift order and bit layout, using a map that uses only the highest-numbered term and input. A design that reverses the chain or swaps the plane offsets drives the wrong output.
- The zero-gating during and right after loading, and cfg_bit activity with the strobe low. A design that shifts without the strobe corrupts a working map.

// File: rtl/pla_pkg.sv
package pla_pkg;
    typedef enum logic [1:0] {
        ST_EMPTY  = 2'd0,
        ST_LOAD   = 2'd1,
        ST_ACTIVE = 2'd2
    } pla_state_t;
endpackage

// File: rtl/pla_cfg_chain.sv
module pla_cfg_chain
    import pla_pkg::*;
#(
    parameter int unsigned CFG_W = 100
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_load,
    input  logic             cfg_bit,
    output logic [CFG_W-1:0] cfg_vec,
    output logic             active
);
    pla_state_t state_q, state_d;
    logic [CFG_W-1:0] chain_q;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_EMPTY;
        else        state_q <= state_d;
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_EMPTY:  if (cfg_load) state_d = ST_LOAD;
            ST_LOAD:   if (!cfg_load) state_d = ST_ACTIVE;
            ST_ACTIVE: if (cfg_load) state_d = ST_LOAD;
            default:   state_d = ST_EMPTY;
        endcase
    end

    // shift chain: first bit in ends at the top index
    always_ff @(posedge clk) begin
        if (!rst_n)        chain_q <= '0;
        else if (cfg_load) chain_q <= {chain_q[CFG_W-2:0], cfg_bit};
    end

    // outputs
    always_comb begin
        cfg_vec = chain_q;
        active  = (state_q == ST_ACTIVE);
    end

    // R11
    hold_cfg_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_load |=> $stable(chain_q));
    // R2
    load_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_load |=> (state_q == ST_LOAD));
    // R3
    go_active_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_LOAD && !cfg_load) |=> (state_q == ST_ACTIVE));
endmodule

// File: rtl/pla_and_plane.sv
module pla_and_plane #(
    parameter int unsigned N_IN   = 4,
    parameter int unsigned N_TERM = 8,
    localparam int unsigned LIT_W = 2 * N_IN
) (
    input  logic [N_IN-1:0]         data_in,
    input  logic [N_TERM*LIT_W-1:0] and_en,
    output logic [N_TERM-1:0]       terms
);
    logic [LIT_W-1:0] lits;

    for (genvar i = 0; i < N_IN; i++) begin : g_lit
        assign lits[2*i]   = data_in[i];
        assign lits[2*i+1] = ~data_in[i];
    end

    for (genvar t = 0; t < N_TERM; t++) begin : g_term
        logic [LIT_W-1:0] en;
        assign en       = and_en[t*LIT_W +: LIT_W];
        assign terms[t] = &(lits | ~en);

        always_comb begin
            // R5
            if (en == '0) begin
                no_lit_term_chk: assert (terms[t] == 1'b1);
            end
            for (int i = 0; i < N_IN; i++) begin
                // R6
                if (en[2*i] && en[2*i+1]) begin
                    contra_term_chk: assert (terms[t] == 1'b0);
                end
            end
        end
    end
endmodule

// File: rtl/pla_or_plane.sv
module pla_or_plane #(
    parameter int unsigned N_TERM = 8,
    parameter int unsigned N_OUT  = 4
) (
    input  logic [N_TERM-1:0]       terms,
    input  logic [N_OUT*N_TERM-1:0] or_en,
    input  logic [N_OUT-1:0]        inv,
    output logic [N_OUT-1:0]        outs
);
    for (genvar o = 0; o < N_OUT; o++) begin : g_out
        logic [N_TERM-1:0] conn;
        logic              sum;
        assign conn    = or_en[o*N_TERM +: N_TERM];
        assign sum     = |(terms & conn);
        assign outs[o] = sum ^ inv[o];

        always_comb begin
            // R8
            if (conn == '0) begin
                empty_out_chk: assert (outs[o] == inv[o]);
            end
        end
    end
endmodule

// File: rtl/pla_array.sv
module pla_array #(
    parameter int unsigned N_IN   = 4,
    parameter int unsigned N_TERM = 8,
    parameter int unsigned N_OUT  = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_load,
    input  logic             cfg_bit,
    input  logic [N_IN-1:0]  data_in,
    output logic [N_OUT-1:0] data_out
);
    localparam int unsigned AND_W = N_TERM * 2 * N_IN;
    localparam int unsigned OR_W  = N_OUT * N_TERM;
    localparam int unsigned CFG_W = AND_W + OR_W + N_OUT;
    localparam int unsigned OR_LO  = N_OUT;
    localparam int unsigned AND_LO = N_OUT + OR_W;

    logic [CFG_W-1:0]  cfg_vec;
    logic              active;
    logic [N_TERM-1:0] terms;
    logic [N_OUT-1:0]  raw_out;

    pla_cfg_chain #(.CFG_W(CFG_W)) u_cfg (
        .clk      (clk),
        .rst_n    (rst_n),
        .cfg_load (cfg_load),
        .cfg_bit  (cfg_bit),
        .cfg_vec  (cfg_vec),
        .active   (active)
    );

    pla_and_plane #(.N_IN(N_IN), .N_TERM(N_TERM)) u_and (
        .data_in (data_in),
        .and_en  (cfg_vec[AND_LO +: AND_W]),
        .terms   (terms)
    );

    pla_or_plane #(.N_TERM(N_TERM), .N_OUT(N_OUT)) u_or (
        .terms (terms),
        .or_en (cfg_vec[OR_LO +: OR_W]),
        .inv   (cfg_vec[N_OUT-1:0]),
        .outs  (raw_out)
    );

    assign data_out = active ? raw_out : '0;

    // R2
    quiet_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_load |=> (data_out == '0));
endmodule

// File: tb/tb_pla_array.sv
`timescale 1ns/1ps
module tb_pla_array;
    localparam int NI = 4, NT = 8, NO = 4;
    localparam int TOT = NT*2*NI + NO*NT + NO;

    logic clk = 1'b0, rst_n = 1'b0, cfg_load = 1'b0, cfg_bit = 1'b0;
    logic [NI-1:0] data_in = '0;
    logic [NO-1:0] data_out;
    int n_chk = 0, n_fail = 0;

    logic [2*NI-1:0] m_and [NT];
    logic [NT-1:0]   m_or  [NO];
    logic [NO-1:0]   m_inv;

    // R12 vectors: {data_in, expected data_out}; out3 inverted empty, out2 empty
    localparam logic [7:0] REF_TAB [16] = '{
        8'h0A, 8'h1B, 8'h2B, 8'h3A, 8'h4A, 8'h59, 8'h68, 8'h79,
        8'h8A, 8'h9B, 8'hAB, 8'hBA, 8'hCA, 8'hD9, 8'hE8, 8'hF9};

    always #2 clk = ~clk;

    pla_array #(.N_IN(NI), .N_TERM(NT), .N_OUT(NO)) dut (
        .clk(clk), .rst_n(rst_n), .cfg_load(cfg_load), .cfg_bit(cfg_bit),
        .data_in(data_in), .data_out(data_out));

    task automatic chk(input string req, input logic [NO-1:0] act, input logic [NO-1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: data_in=%h got %h expected %h", req, data_in, act, exp);
        end
    endtask

    function automatic logic [NO-1:0] model(input logic [NI-1:0] x);
        logic [NT-1:0] tv;
        for (int t = 0; t < NT; t++) begin
            tv[t] = 1'b1;
            for (int i = 0; i < NI; i++) begin
                if (m_and[t][2*i]   && !x[i]) tv[t] = 1'b0;
                if (m_and[t][2*i+1] &&  x[i]) tv[t] = 1'b0;
            end
        end
        for (int o = 0; o < NO; o++) model[o] = (|(tv & m_or[o])) ^ m_inv[o];
    endfunction

    task automatic clear_map();
        for (int t = 0; t < NT; t++) m_and[t] = '0;
        for (int o = 0; o < NO; o++) m_or[o] = '0;
        m_inv = '0;
    endtask

    // R10 layout, highest index shifted first; R2 and R3 gating checked on the way
    task automatic load_map();
        logic [TOT-1:0] v;
        v = '0;
        for (int o = 0; o < NO; o++) v[o] = m_inv[o];
        for (int o = 0; o < NO; o++)
            for (int t = 0; t < NT; t++) v[NO + o*NT + t] = m_or[o][t];
        for (int t = 0; t < NT; t++)
            for (int b = 0; b < 2*NI; b++) v[NO + NO*NT + t*2*NI + b] = m_and[t][b];
        @(negedge clk);
        cfg_load = 1'b1;
        for (int k = TOT-1; k >= 0; k--) begin
            cfg_bit = v[k];
            if (k == TOT/2) begin
                data_in = '1; #1;
                chk("R2 zero while loading", data_out, '0);
            end
            @(negedge clk);
        end
        cfg_load = 1'b0;
        cfg_bit  = 1'b0;
        #1 chk("R3 zero before activation edge", data_out, '0);
        @(negedge clk);
    endtask

    task automatic sweep(input string req);
        for (int x = 0; x < 16; x++) begin
            data_in = x[NI-1:0];
            #1 chk(req, data_out, model(x[NI-1:0]));
        end
    endtask

    initial begin
        #(200000*4);
        n_fail++;
        $display("FAIL watchdog: run did not finish");
        $display("%0d/%0d checks passed", n_chk + 1 - n_fail, n_chk + 1);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset and unconfigured state
        data_in = 4'h5; #1 chk("R1 output in reset", data_out, '0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        for (int x = 0; x < 16; x += 5) begin
            data_in = x[NI-1:0];
            #1 chk("R1 empty after reset", data_out, '0);
        end

        // R12/R7/R9 reference two-function map, shared term t1 = A.C
        clear_map();
        m_and[0] = 8'b0000_1001;   // A B'
        m_and[1] = 8'b0001_0001;   // A C
        m_and[2] = 8'b0010_0110;   // A' B C'
        m_and[3] = 8'b0001_0100;   // B C
        m_or[0]  = 8'b0000_0111;
        m_or[1]  = 8'b0000_1010;
        m_inv    = 4'b1010;        // invert F2 and empty out3 (R8)
        load_map();
        for (int k = 0; k < 16; k++) begin
            data_in = REF_TAB[k][7:4];
            #1 chk("R12 two-function table", data_out, REF_TAB[k][3:0]);
        end
        sweep("R4 R7 R9 model sweep");

        // R11: toggle cfg_bit with strobe low, map must survive
        for (int k = 0; k < 12; k++) begin
            cfg_bit = k[0];
            @(negedge clk);
        end
        cfg_bit = 1'b0;
        sweep("R11 cfg_bit ignored");

        // R5/R6/R8: empty term, contradictory term, empty outputs
        clear_map();
        m_and[1] = 8'b0000_0011;   // A & A'
        m_or[0]  = 8'b0000_0001;   // empty term -> 1
        m_or[1]  = 8'b0000_0010;   // contradictory -> 0
        m_or[2]  = 8'b0000_0010;
        m_or[3]  = 8'b0000_0011;
        m_inv    = 4'b1100;
        load_map();
        for (int x = 0; x < 16; x++) begin
            data_in = x[NI-1:0];
            #1 chk("R5 R6 constant terms", data_out, 4'b0101);
        end
        clear_map();
        m_inv = 4'b0110;
        load_map();
        sweep("R8 empty outputs show invert");
        data_in = 4'h0; #1 chk("R8 empty outputs direct", data_out, 4'b0110);

        // R10: top term and top input only -> out3 = data_in[3]
        clear_map();
        m_and[7] = 8'b0100_0000;
        m_or[3]  = 8'b1000_0000;
        load_map();
        data_in = 4'h8; #1 chk("R10 top term on out3", data_out, 4'b1000);
        data_in = 4'h7; #1 chk("R10 top term off", data_out, 4'b0000);
        sweep("R10 layout sweep");

        // R1: reset after configuration returns to empty
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        data_in = 4'h8; #1 chk("R1 empty after second reset", data_out, '0);

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule